// File: doc/BRIEF.md
# Expansion ROM Read Timing Controller

This block carries out single-byte reads from an external parallel Flash or EPROM for a requester on the host side. A request latches a 20-bit byte address. The block then waits for the next edge of a slow strobe clock, which is a divide-by-four enable taken from the reference clock. It drives the address with a valid strobe for a programmable number of slow-clock cycles. At the end of the last cycle it registers the 8-bit data bus and returns that byte with a one-cycle done pulse.

The hold length comes from a 4-bit timing setting held in the block. The setting resets to 9. It returns to 9 whenever a configuration load begins or fails, and a host write can change it at any other time. A setting of zero is never used as a length: it counts as one slow cycle. The chosen value is expected to cover the device access time plus one slow cycle of margin, which absorbs the output delay of the address and the setup time of the data. The length is latched when a request is accepted, so a write during an access affects only later accesses.

The sequencer has four states. ST_IDLE goes to ST_ALIGN when a request arrives. ST_ALIGN goes to ST_HOLD on the next slow-clock enable. ST_HOLD goes to ST_DONE on the enable that ends its Nth slow cycle, and it captures the data on that same edge. ST_DONE returns to ST_IDLE after one cycle.

Top module: `exprom_read_ctrl`

## Requirements
- R1: During and right after reset, busy, done and rom_strobe are 0, and rom_addr and rd_data are 0.
- R2: The slow-clock enable fires once every 4 reference cycles and runs freely from reset. rom_strobe rises only on a slow-clock boundary, between 1 and 4 cycles after the cycle in which the request was accepted. Every rise falls on the same phase modulo 4.
- R3: rom_strobe stays high for exactly 4*N consecutive reference cycles, where N is the timing setting latched when the request was accepted.
- R4: A timing setting of 0 acts as N=1, so the strobe is high for 4 cycles.
- R5: After hard reset the timing setting is 9, which gives a strobe of 36 cycles.
- R6: Pulsing cfg_load_start or cfg_load_fail returns the setting to 9. This takes priority over a tmg_wr_en write in the same cycle.
- R7: tmg_wr_en loads tmg_wr_val into the setting. A write made during an access does not change the length of that access, but it does set the length of the next one.
- R8: rom_addr equals the accepted req_addr and stays unchanged from acceptance until the next acceptance.
- R9: rd_data is the value that rom_data_in had in the final reference cycle of the strobe. It is valid while done is high and holds until the next capture.
- R10: done is a single-cycle pulse in the cycle right after rom_strobe falls.
- R11: busy is 1 from the cycle after acceptance through the done cycle, and 0 after that. While busy is 1, req is ignored: it does not change the address, adds no extra done, and does not extend the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low hard reset |
| cfg_load_start | input | 1 | Configuration load is beginning; sets the timing setting to its default |
| cfg_load_fail | input | 1 | Configuration load failed; sets the timing setting to its default |
| tmg_wr_en | input | 1 | Write strobe for the timing setting |
| tmg_wr_val | input | 4 | New timing setting, in slow-clock cycles |
| req | input | 1 | Read request, sampled while idle |
| req_addr | input | 20 | Byte address of the request |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | 8 | Byte returned by the last access |
| rom_addr | output | 20 | Address driven to the memory |
| rom_strobe | output | 1 | The address is valid and the access is running |
| rom_data_in | input | 8 | Data bus from the memory |

## Verification
The assertions assume that rst_n is low for at least one clock edge before any request. They also assume that req_addr may change freely while busy is high, because the address check depends on the request being ignored. The bench changes its inputs only on falling clock edges. It holds a request for exactly one rising edge, and it keeps tmg_wr_en and the load pulses to single cycles, so each rising edge sees at most one event of each kind. Requests made during an access, and timing writes made during an access, are placed at fixed cycles inside the strobe window. This lets the expected length and address be worked out directly.

// File: rtl/exprom_pkg.sv
package exprom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DONE  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/exprom_slow_en.sv
module exprom_slow_en #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic slow_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end

    assign slow_tick = (phase_q == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> !slow_tick);

endmodule

// File: rtl/exprom_tmg_reg.sv
module exprom_tmg_reg #(
    parameter int              TMG_W   = 4,
    parameter logic [TMG_W-1:0] TMG_RST = 4'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load_start,
    input  logic             cfg_load_fail,
    input  logic             tmg_wr_en,
    input  logic [TMG_W-1:0] tmg_wr_val,
    output logic [TMG_W-1:0] tmg_eff
);
    logic [TMG_W-1:0] tmg_q;
    logic             to_default;

    assign to_default = cfg_load_start | cfg_load_fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmg_q <= TMG_RST;
        end else if (to_default) begin
            tmg_q <= TMG_RST;
        end else if (tmg_wr_en) begin
            tmg_q <= tmg_wr_val;
        end
    end

    // a zero setting is coerced to a single slow cycle
    assign tmg_eff = (tmg_q == '0) ? TMG_W'(1) : tmg_q;

    // R6
    load_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_default |=> tmg_q == TMG_RST);

    // R7
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmg_wr_en && !to_default) |=> tmg_q == $past(tmg_wr_val));

endmodule

// File: rtl/exprom_seq.sv
module exprom_seq
    import exprom_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int TMG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [TMG_W-1:0]  tmg_eff,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] rom_data_in,
    output logic              busy,
    output logic              done,
    output logic              rom_strobe,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rd_data
);
    rd_state_e        state_q, state_d;
    logic [TMG_W-1:0] len_q;
    logic [TMG_W-1:0] slot_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              last_slot;

    assign accept    = (state_q == ST_IDLE) && req;
    assign last_slot = (slot_q == len_q - TMG_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_ALIGN;
            ST_ALIGN: if (slow_tick) state_d = ST_HOLD;
            ST_HOLD:  if (slow_tick && last_slot) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        rom_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ALIGN: busy = 1'b1;
            ST_HOLD:  begin busy = 1'b1; rom_strobe = 1'b1; end
            ST_DONE:  begin busy = 1'b1; done = 1'b1; end
            default:  ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            len_q  <= TMG_W'(1);
            slot_q <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                len_q  <= tmg_eff;
            end
            if (state_q == ST_ALIGN) begin
                slot_q <= '0;
            end else if (state_q == ST_HOLD && slow_tick) begin
                slot_q <= slot_q + TMG_W'(1);
                if (last_slot) begin
                    data_q <= rom_data_in;
                end
            end
        end
    end

    assign rom_addr = addr_q;
    assign rd_data  = data_q;

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> rom_addr == $past(rom_addr));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_strobe) |-> done);

    // R4
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_strobe |-> len_q != '0);

    // R2
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_strobe) |-> $past(slow_tick));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && busy) |=> rom_addr == $past(rom_addr));

    // R9
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(rom_strobe)) |-> $stable(rd_data));

endmodule

// File: rtl/exprom_read_ctrl.sv
module exprom_read_ctrl #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int TMG_W   = 4,
    parameter int DIV     = 4,
    parameter int TMG_DEF = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load_start,
    input  logic              cfg_load_fail,
    input  logic              tmg_wr_en,
    input  logic [TMG_W-1:0]  tmg_wr_val,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_strobe,
    input  logic [DATA_W-1:0] rom_data_in
);
    localparam logic [TMG_W-1:0] TMG_RST = TMG_W'(TMG_DEF);

    logic             slow_tick;
    logic [TMG_W-1:0] tmg_eff;

    exprom_slow_en #(
        .DIV (DIV)
    ) u_slow (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick)
    );

    exprom_tmg_reg #(
        .TMG_W   (TMG_W),
        .TMG_RST (TMG_RST)
    ) u_tmg (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_load_start (cfg_load_start),
        .cfg_load_fail  (cfg_load_fail),
        .tmg_wr_en      (tmg_wr_en),
        .tmg_wr_val     (tmg_wr_val),
        .tmg_eff        (tmg_eff)
    );

    exprom_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TMG_W  (TMG_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .tmg_eff     (tmg_eff),
        .req         (req),
        .req_addr    (req_addr),
        .rom_data_in (rom_data_in),
        .busy        (busy),
        .done        (done),
        .rom_strobe  (rom_strobe),
        .rom_addr    (rom_addr),
        .rd_data     (rd_data)
    );

endmodule

// File: tb/exprom_read_ctrl_tb.sv
`timescale 1ns/1ps
module exprom_read_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load_start = 1'b0;
    logic        cfg_load_fail = 1'b0;
    logic        tmg_wr_en = 1'b0;
    logic [3:0]  tmg_wr_val = 4'd0;
    logic        req = 1'b0;
    logic [19:0] req_addr = 20'd0;
    logic        busy;
    logic        done;
    logic [7:0]  rd_data;
    logic [19:0] rom_addr;
    logic        rom_strobe;
    logic [7:0]  rom_data_in = 8'd0;

    int total = 0;
    int bad = 0;
    int cyc_total = 0;
    int ref_rise = -1;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    exprom_read_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_load_start (cfg_load_start),
        .cfg_load_fail  (cfg_load_fail),
        .tmg_wr_en      (tmg_wr_en),
        .tmg_wr_val     (tmg_wr_val),
        .req            (req),
        .req_addr       (req_addr),
        .busy           (busy),
        .done           (done),
        .rd_data        (rd_data),
        .rom_addr       (rom_addr),
        .rom_strobe     (rom_strobe),
        .rom_data_in    (rom_data_in)
    );

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 100000 && !finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc_total);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] patt(input logic [19:0] a, input int k);
        return a[7:0] ^ a[19:12] ^ 8'(k * 37);
    endfunction

    task automatic set_tmg(input logic [3:0] v);
        @(negedge clk);
        tmg_wr_en = 1'b1; tmg_wr_val = v;
        @(negedge clk);
        tmg_wr_en = 1'b0;
    endtask

    task automatic run_read(input logic [19:0] a, input int n_exp,
                            input bit poke_busy, input bit poke_tmg,
                            input logic [3:0] newv);
        int c, k, first, rise_abs;
        bit seen_done, addr_ok, extra_done;
        logic [19:0] addr_seen;
        @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        c = 1; k = 0; first = -1; rise_abs = 0;
        seen_done = 1'b0; addr_ok = 1'b1; addr_seen = a;
        // R11: busy the cycle after acceptance
        chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
        while (!seen_done && c < 200) begin
            if (rom_strobe) begin
                if (first < 0) begin first = c; rise_abs = cyc_total; end
                k++;
                if (rom_addr != a) begin addr_ok = 1'b0; addr_seen = rom_addr; end
            end
            rom_data_in = patt(a, k);
            if (done) begin
                seen_done = 1'b1;
            end else begin
                if (poke_busy && c == 3) begin req = 1'b1; req_addr = ~a; end
                if (poke_busy && c == 4) begin req = 1'b0; end
                if (poke_tmg && c == 6) begin tmg_wr_en = 1'b1; tmg_wr_val = newv; end
                if (poke_tmg && c == 7) begin tmg_wr_en = 1'b0; end
                @(negedge clk);
                c++;
            end
        end
        chk(seen_done, "R10 done seen", int'(seen_done), 1);
        // R3 / R4 / R5 strobe length
        chk(k == 4 * n_exp, "R3 strobe length", k, 4 * n_exp);
        // R2 strobe start window
        chk(first >= 2 && first <= 5, "R2 strobe start", first, 2);
        if (ref_rise < 0) ref_rise = rise_abs;
        chk(((rise_abs - ref_rise) % 4) == 0, "R2 strobe phase",
            (rise_abs - ref_rise) % 4, 0);
        // R10 done right after strobe
        chk(c == first + 4 * n_exp, "R10 done timing", c, first + 4 * n_exp);
        // R8 address held
        chk(addr_ok, "R8 address held", int'(addr_seen), int'(a));
        // R9 captured byte
        chk(rd_data == patt(a, 4 * n_exp), "R9 read data", int'(rd_data),
            int'(patt(a, 4 * n_exp)));
        chk(busy == 1'b1, "R11 busy at done", int'(busy), 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single pulse", int'(done), 0);
        chk(busy == 1'b0, "R11 busy released", int'(busy), 0);
        if (poke_busy) begin
            extra_done = 1'b0;
            for (int i = 0; i < 8; i++) begin
                if (done || busy || rom_strobe) extra_done = 1'b1;
                @(negedge clk);
            end
            chk(!extra_done, "R11 request while busy ignored", int'(extra_done), 0);
            chk(rom_addr == a, "R11 address unchanged", int'(rom_addr), int'(a));
        end
        // R9 data held after done
        chk(rd_data == patt(a, 4 * n_exp), "R9 data held", int'(rd_data),
            int'(patt(a, 4 * n_exp)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0 && rom_strobe == 1'b0, "R1 reset controls",
            int'({busy, done, rom_strobe}), 0);
        chk(rom_addr == 20'd0 && rd_data == 8'd0, "R1 reset data",
            int'(rom_addr) + int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && rom_strobe == 1'b0, "R1 after reset idle",
            int'({busy, rom_strobe}), 0);

        // R5 default setting is 9
        run_read(20'hA5C31, 9, 1'b0, 1'b0, 4'd0);

        // R3 / R4 sweep of every setting (0 behaves as 1)
        for (int v = 0; v < 16; v++) begin
            set_tmg(4'(v));
            run_read(20'(v * 4099 + 17), (v == 0) ? 1 : v, 1'b0, 1'b0, 4'd0);
            run_read(20'hFFFFF - 20'(v * 333), (v == 0) ? 1 : v, 1'b0, 1'b0, 4'd0);
        end

        // R6 load start overrides a simultaneous write
        set_tmg(4'd3);
        @(negedge clk);
        cfg_load_start = 1'b1; tmg_wr_en = 1'b1; tmg_wr_val = 4'd5;
        @(negedge clk);
        cfg_load_start = 1'b0; tmg_wr_en = 1'b0;
        run_read(20'h12345, 9, 1'b0, 1'b0, 4'd0);

        // R6 load failure restores the default
        set_tmg(4'd2);
        @(negedge clk);
        cfg_load_fail = 1'b1;
        @(negedge clk);
        cfg_load_fail = 1'b0;
        run_read(20'h0F0F0, 9, 1'b0, 1'b0, 4'd0);

        // R7 write mid-access only affects the next access
        set_tmg(4'd2);
        run_read(20'h55AA5, 2, 1'b0, 1'b1, 4'd12);
        run_read(20'hAA55A, 12, 1'b0, 1'b0, 4'd0);

        // R11 request during an access is ignored
        set_tmg(4'd4);
        run_read(20'h3C3C3, 4, 1'b1, 1'b0, 4'd0);
        run_read(20'h00001, 4, 1'b1, 1'b0, 4'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule